// File: doc/BRIEF.md
# Dual Page-Size Data TLB

This block is a first-level data translation buffer. A load or store presents a 48-bit virtual address together with its access kind (read or write) and the privilege of the requester (user or kernel). In the same cycle the block returns a hit flag, a 40-bit physical address and a fault flag. Two set-associative arrays are searched in parallel. One maps 4 KB pages and the other maps 2 MB pages.

When both arrays are empty for an address, the block reports neither hit nor fault. An external walker then resolves the translation and installs it through the fill port. The block makes no request of its own. A one-cycle flush input invalidates every entry in both arrays. Each entry records whether it may be written and whether user code may touch it. An access that breaks either rule raises the fault flag and does not hit.

Top module: `dual_page_dtlb`

## Requirements
- R1: A lookup resolves combinationally in the cycle it is presented. On a small-page hit, lk_paddr = {stored 28-bit frame, lk_vaddr[11:0]}.
- R2: On a large-page hit, lk_paddr = {stored 19-bit frame, lk_vaddr[20:0]}. For a large fill, the stored frame is fill_ppn[27:9], and fill_ppn[8:0] is ignored.
- R3: The small array has 16 sets of 4 ways, with set = vaddr[15:12] and tag = vaddr[47:16]. The large array has 8 sets of 4 ways, with set = vaddr[23:21] and tag = vaddr[47:24]. If several ways of one array match, the lowest-numbered way is used.
- R4: When both arrays match, the large-page entry decides the result.
- R5: A matching access faults when lk_user=1 and the entry is not user-accessible, or when lk_write=1 and the entry is not writable. A fault sets lk_fault=1, lk_hit=0 and lk_paddr=0. Hit and fault are never both set.
- R6: With no matching valid entry, or with lk_valid=0, lk_hit=0, lk_fault=0 and lk_paddr=0.
- R7: A fill takes effect at the next rising edge. It goes to the lowest-numbered invalid way of the selected set, and in that case the set's replacement pointer is left unchanged.
- R8: A fill into a set whose ways are all valid replaces the way named by that set's pointer. The pointer starts at 0 and then advances by one, modulo 4.
- R9: Flush clears every valid bit and every replacement pointer at the next edge. A fill in the same cycle as a flush is dropped.
- R10: After reset, no entry is valid and all pointers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_write | input | 1 | 1 = store access, 0 = load access |
| lk_user | input | 1 | 1 = user-mode access, 0 = kernel-mode access |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_fault | output | 1 | Translation found but access not permitted |
| lk_paddr | output | 40 | Translated physical address, zero unless hit |
| fill_en | input | 1 | Install a new entry |
| fill_large | input | 1 | 1 = 2 MB entry, 0 = 4 KB entry |
| fill_vaddr | input | 48 | Virtual address whose page is installed |
| fill_ppn | input | 28 | Physical frame number in 4 KB units |
| fill_writable | input | 1 | Entry may be written |
| fill_user | input | 1 | Entry is accessible from user mode |
| flush | input | 1 | Invalidate all entries |

## Verification
The assertions take for granted that fill_en and flush are held low during reset. They also assume that a fill naming a page is followed one cycle later by a lookup of that page only when the fill was not cancelled by a flush. The stimulus drives all control inputs low while reset is held, and it changes inputs only away from the clock edge. Random tags are drawn from a small range so that set conflicts, evictions, duplicate tags and overlap between the two page sizes happen often. Any duplicates that arise are resolved by the lowest-way rule, which the bench model implements.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
    localparam int VA_W     = 48;
    localparam int PA_W     = 40;
    localparam int SM_OFF_W = 12;
    localparam int LG_OFF_W = 21;
    localparam int SM_VPN_W = VA_W - SM_OFF_W;
    localparam int LG_VPN_W = VA_W - LG_OFF_W;
    localparam int SM_PPN_W = PA_W - SM_OFF_W;
    localparam int LG_PPN_W = PA_W - LG_OFF_W;
    localparam int TAG_MAX  = 40;
    localparam int PPN_MAX  = SM_PPN_W;

    typedef struct packed {
        logic                 valid;
        logic                 wr;
        logic                 usr;
        logic [TAG_MAX-1:0]   tag;
        logic [PPN_MAX-1:0]   ppn;
    } tlb_entry_t;
endpackage

// File: rtl/dtlb_set_array.sv
module dtlb_set_array
    import dtlb_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int VPN_W = 36,
    parameter int PPN_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit_o,
    output logic [PPN_W-1:0] ppn_o,
    output logic             wr_o,
    output logic             usr_o,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr,
    input  logic             fill_usr,
    input  logic             flush
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    tlb_entry_t       ent_d [SETS][WAYS];
    tlb_entry_t       ent_q [SETS][WAYS];
    logic [WAY_W-1:0] rr_d  [SETS];
    logic [WAY_W-1:0] rr_q  [SETS];

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] fl_idx;
    logic [TAG_W-1:0] fl_tag;

    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign fl_idx = fill_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

    // Lookup: scan high to low so the lowest matching way wins.
    always_comb begin
        hit_o = 1'b0;
        ppn_o = '0;
        wr_o  = 1'b0;
        usr_o = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (ent_q[lk_idx][w].valid && ent_q[lk_idx][w].tag[TAG_W-1:0] == lk_tag) begin
                hit_o = 1'b1;
                ppn_o = ent_q[lk_idx][w].ppn[PPN_W-1:0];
                wr_o  = ent_q[lk_idx][w].wr;
                usr_o = ent_q[lk_idx][w].usr;
            end
        end
    end

    // Next-state: flush beats fill; invalid ways before round-robin victim.
    always_comb begin
        tlb_entry_t       new_e;
        logic [WAY_W-1:0] victim;
        logic             free_found;
        ent_d      = ent_q;
        rr_d       = rr_q;
        new_e      = '0;
        victim     = rr_q[fl_idx];
        free_found = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!ent_q[fl_idx][w].valid) begin
                victim     = WAY_W'(w);
                free_found = 1'b1;
            end
        end
        new_e.valid               = 1'b1;
        new_e.wr                  = fill_wr;
        new_e.usr                 = fill_usr;
        new_e.tag[TAG_W-1:0]      = fl_tag;
        new_e.ppn[PPN_W-1:0]      = fill_ppn;
        if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                rr_d[s] = '0;
                for (int w = 0; w < WAYS; w++) begin
                    ent_d[s][w].valid = 1'b0;
                end
            end
        end else if (fill_en) begin
            ent_d[fl_idx][victim] = new_e;
            if (!free_found) begin
                rr_d[fl_idx] = rr_q[fl_idx] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '{default: '0};
            rr_q  <= '{default: '0};
        end else begin
            ent_q <= ent_d;
            rr_q  <= rr_d;
        end
    end
endmodule

// File: rtl/dtlb_perm_check.sv
module dtlb_perm_check (
    input  logic acc_write,
    input  logic acc_user,
    input  logic ent_wr,
    input  logic ent_usr,
    output logic violation
);
    logic user_bad;
    logic write_bad;
    assign user_bad  = acc_user && !ent_usr;
    assign write_bad = acc_write && !ent_wr;
    assign violation = user_bad || write_bad;
endmodule

// File: rtl/dual_page_dtlb.sv
module dual_page_dtlb
    import dtlb_pkg::*;
#(
    parameter int SM_SETS = 16,
    parameter int LG_SETS = 8,
    parameter int N_WAYS  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    input  logic [47:0] lk_vaddr,
    input  logic        lk_write,
    input  logic        lk_user,
    output logic        lk_hit,
    output logic        lk_fault,
    output logic [39:0] lk_paddr,
    input  logic        fill_en,
    input  logic        fill_large,
    input  logic [47:0] fill_vaddr,
    input  logic [27:0] fill_ppn,
    input  logic        fill_writable,
    input  logic        fill_user,
    input  logic        flush
);
    localparam int N_ARR = 2;

    logic [N_ARR-1:0] arr_hit;
    logic [N_ARR-1:0] arr_wr;
    logic [N_ARR-1:0] arr_usr;
    logic [SM_PPN_W-1:0] sm_ppn;
    logic [LG_PPN_W-1:0] lg_ppn;

    generate
        for (genvar a = 0; a < N_ARR; a++) begin : g_arr
            if (a == 0) begin : g_small
                dtlb_set_array #(
                    .SETS(SM_SETS), .WAYS(N_WAYS), .VPN_W(SM_VPN_W), .PPN_W(SM_PPN_W)
                ) i_arr (
                    .clk(clk), .rst_n(rst_n),
                    .lk_vpn(lk_vaddr[VA_W-1:SM_OFF_W]),
                    .hit_o(arr_hit[a]), .ppn_o(sm_ppn),
                    .wr_o(arr_wr[a]), .usr_o(arr_usr[a]),
                    .fill_en(fill_en && !fill_large),
                    .fill_vpn(fill_vaddr[VA_W-1:SM_OFF_W]),
                    .fill_ppn(fill_ppn),
                    .fill_wr(fill_writable), .fill_usr(fill_user),
                    .flush(flush)
                );
            end else begin : g_large
                dtlb_set_array #(
                    .SETS(LG_SETS), .WAYS(N_WAYS), .VPN_W(LG_VPN_W), .PPN_W(LG_PPN_W)
                ) i_arr (
                    .clk(clk), .rst_n(rst_n),
                    .lk_vpn(lk_vaddr[VA_W-1:LG_OFF_W]),
                    .hit_o(arr_hit[a]), .ppn_o(lg_ppn),
                    .wr_o(arr_wr[a]), .usr_o(arr_usr[a]),
                    .fill_en(fill_en && fill_large),
                    .fill_vpn(fill_vaddr[VA_W-1:LG_OFF_W]),
                    .fill_ppn(fill_ppn[SM_PPN_W-1:SM_PPN_W-LG_PPN_W]),
                    .fill_wr(fill_writable), .fill_usr(fill_user),
                    .flush(flush)
                );
            end
        end
    endgenerate

    // Large page has priority when both arrays match.
    logic        sel_large;
    logic        any_match;
    logic        sel_wr;
    logic        sel_usr;
    logic        viol;
    logic [39:0] xlated;

    assign sel_large = arr_hit[1];
    assign any_match = lk_valid && (arr_hit[0] || arr_hit[1]);
    assign sel_wr    = sel_large ? arr_wr[1]  : arr_wr[0];
    assign sel_usr   = sel_large ? arr_usr[1] : arr_usr[0];
    assign xlated    = sel_large ? {lg_ppn, lk_vaddr[LG_OFF_W-1:0]}
                                 : {sm_ppn, lk_vaddr[SM_OFF_W-1:0]};

    dtlb_perm_check i_perm (
        .acc_write(lk_write), .acc_user(lk_user),
        .ent_wr(sel_wr), .ent_usr(sel_usr),
        .violation(viol)
    );

    assign lk_hit   = any_match && !viol;
    assign lk_fault = any_match && viol;
    assign lk_paddr = lk_hit ? xlated : '0;
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [47:0] lk_vaddr,
    input logic        lk_write,
    input logic        lk_user,
    input logic        lk_hit,
    input logic        lk_fault,
    input logic [39:0] lk_paddr,
    input logic        fill_en,
    input logic        fill_large,
    input logic [47:0] fill_vaddr,
    input logic [27:0] fill_ppn,
    input logic        fill_writable,
    input logic        fill_user,
    input logic        flush
);
    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_fault));

    assert_zero_pa_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));

    assert_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_hit && !lk_fault));

    assert_fill_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(fill_en && !flush && !fill_large)
         && lk_vaddr[47:12] == $past(fill_vaddr[47:12]))
        |-> (lk_hit || lk_fault));
endmodule

bind dual_page_dtlb dtlb_checker i_dtlb_checker (.*);

// File: tb/test_dual_page_dtlb.sv
module test_dual_page_dtlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_hit;
    logic        lk_fault;
    logic [39:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic        fill_large = 1'b0;
    logic [47:0] fill_vaddr = '0;
    logic [27:0] fill_ppn = '0;
    logic        fill_writable = 1'b0;
    logic        fill_user = 1'b0;
    logic        flush = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_page_dtlb i_dual_page_dtlb (.*);

    // Reference state
    bit          s_v [16][4];
    bit          s_w [16][4];
    bit          s_u [16][4];
    logic [31:0] s_t [16][4];
    logic [27:0] s_p [16][4];
    int          s_rr[16];
    bit          l_v [8][4];
    bit          l_w [8][4];
    bit          l_u [8][4];
    logic [23:0] l_t [8][4];
    logic [18:0] l_p [8][4];
    int          l_rr[8];

    task automatic model_clear();
        for (int s = 0; s < 16; s++) begin
            s_rr[s] = 0;
            for (int w = 0; w < 4; w++) s_v[s][w] = 0;
        end
        for (int s = 0; s < 8; s++) begin
            l_rr[s] = 0;
            for (int w = 0; w < 4; w++) l_v[s][w] = 0;
        end
    endtask

    task automatic model_fill();
        int vic;
        int found;
        found = 0;
        if (!fill_large) begin
            int s;
            s = int'(fill_vaddr[15:12]);
            vic = s_rr[s];
            for (int w = 3; w >= 0; w--) if (!s_v[s][w]) begin vic = w; found = 1; end
            if (found == 0) s_rr[s] = (s_rr[s] + 1) % 4;
            s_v[s][vic] = 1; s_w[s][vic] = fill_writable; s_u[s][vic] = fill_user;
            s_t[s][vic] = fill_vaddr[47:16]; s_p[s][vic] = fill_ppn;
        end else begin
            int s;
            s = int'(fill_vaddr[23:21]);
            vic = l_rr[s];
            for (int w = 3; w >= 0; w--) if (!l_v[s][w]) begin vic = w; found = 1; end
            if (found == 0) l_rr[s] = (l_rr[s] + 1) % 4;
            l_v[s][vic] = 1; l_w[s][vic] = fill_writable; l_u[s][vic] = fill_user;
            l_t[s][vic] = fill_vaddr[47:24]; l_p[s][vic] = fill_ppn[27:9];
        end
    endtask

    function automatic logic [41:0] model_out();
        int sw; int lw; int ss; int ls;
        bit ew; bit eu;
        logic [39:0] pa;
        sw = -1; lw = -1;
        ss = int'(lk_vaddr[15:12]);
        ls = int'(lk_vaddr[23:21]);
        if (!lk_valid) return '0;
        for (int w = 3; w >= 0; w--) begin
            if (s_v[ss][w] && s_t[ss][w] == lk_vaddr[47:16]) sw = w;
            if (l_v[ls][w] && l_t[ls][w] == lk_vaddr[47:24]) lw = w;
        end
        if (lw >= 0) begin
            ew = l_w[ls][lw]; eu = l_u[ls][lw]; pa = {l_p[ls][lw], lk_vaddr[20:0]};
        end else if (sw >= 0) begin
            ew = s_w[ss][sw]; eu = s_u[ss][sw]; pa = {s_p[ss][sw], lk_vaddr[11:0]};
        end else return '0;
        if ((lk_user && !eu) || (lk_write && !ew)) return {1'b0, 1'b1, 40'h0};
        return {1'b1, 1'b0, pa};
    endfunction

    task automatic check(input string req);
        logic [41:0] exp;
        logic [41:0] act;
        exp = model_out();
        act = {lk_hit, lk_fault, lk_paddr};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s va=%h act hit/fault/pa=%h expected %h", req, lk_vaddr, act, exp);
        end
    endtask

    // One cycle: inputs already set after a negedge; check, then advance.
    task automatic cyc(input string req);
        #1;
        if (lk_valid) check(req);
        if (rst_n) begin
            if (flush) model_clear();
            else if (fill_en) model_fill();
        end
        @(negedge clk);
    endtask

    task automatic idle();
        lk_valid = 0; fill_en = 0; flush = 0;
    endtask

    task automatic do_fill(input bit lg, input logic [47:0] va, input logic [27:0] p,
                           input bit w, input bit u);
        idle();
        fill_en = 1; fill_large = lg; fill_vaddr = va; fill_ppn = p;
        fill_writable = w; fill_user = u;
        cyc("R7");
    endtask

    task automatic do_look(input logic [47:0] va, input bit wr, input bit us, input string req);
        idle();
        lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = us;
        cyc(req);
    endtask

    function automatic logic [47:0] sm_va(input int tag, input int set);
        return {32'(tag), 4'(set), 12'($urandom)};
    endfunction

    function automatic logic [47:0] lg_va(input int tag, input int set);
        return {24'(tag), 3'(set), 21'($urandom)};
    endfunction

    function automatic string tag_for();
        logic [41:0] e;
        e = model_out();
        if (e[40]) return "R5";
        if (!e[41]) return "R6";
        if (e[39:0] != '0 && lk_vaddr[20:12] != 9'h0) return "R2/R1";
        return "R1";
    endfunction

    initial begin
        void'($urandom(32'd4711));
        model_clear();
        // R10: nothing valid while and after reset
        lk_valid = 1; lk_vaddr = 48'h0000_1234_5000;
        @(negedge clk);
        cyc("R10");
        @(negedge clk);
        rst_n = 1;
        do_look(48'h0, 0, 0, "R10");
        do_look(48'hABCD_EF01_2345, 1, 1, "R10");

        // R1 small hit, R3 set/tag split
        do_fill(0, 48'h0000_0002_3000, 28'hABC_DEF0, 1, 1);
        do_look(48'h0000_0002_3FFF, 0, 0, "R1");
        do_look(48'h0000_0012_3FFF, 0, 0, "R3");   // different tag, same set -> miss
        do_look(48'h0000_0002_4000, 0, 0, "R3");   // different set -> miss
        // R2 large hit, low ppn bits ignored
        do_fill(1, 48'h0000_0060_0000, 28'h123_45FF, 1, 1);
        do_look(48'h0000_007F_FFFF, 1, 1, "R2");
        // R4 overlap: large page covering small page 0x00002_3000? use matching region
        do_fill(1, 48'h0000_0000_0000, 28'h777_7000, 1, 1);
        do_look(48'h0000_0002_3456, 0, 0, "R4");
        // R5 permission faults
        do_fill(0, 48'h0000_1000_5000, 28'h000_0055, 0, 0);
        do_look(48'h0000_1000_5010, 0, 1, "R5");   // user on kernel page
        do_look(48'h0000_1000_5010, 1, 0, "R5");   // write on read-only
        do_look(48'h0000_1000_5010, 0, 0, "R5");   // permitted read
        // R6 lk_valid low
        idle(); lk_vaddr = 48'h0000_0002_3000; #1;
        checks++;
        if (lk_hit !== 0 || lk_fault !== 0 || lk_paddr !== '0) begin
            fails++; $display("FAIL R6 idle act=%b%b expected 00", lk_hit, lk_fault);
        end
        cyc("R6");

        // R9 flush, then R7/R8 eviction order in small set 9
        idle(); flush = 1; cyc("R9");
        do_look(48'h0000_0002_3000, 0, 0, "R9");
        for (int i = 0; i < 6; i++) do_fill(0, sm_va(100 + i, 9), 28'(i + 1), 1, 1);
        for (int i = 0; i < 6; i++) do_look(sm_va(100 + i, 9), 0, 0, "R8");
        // R9 fill dropped when flush shares the cycle
        idle(); flush = 1; fill_en = 1; fill_large = 0; fill_vaddr = sm_va(7, 2);
        fill_ppn = 28'h5; cyc("R9");
        do_look(sm_va(7, 2), 0, 0, "R9");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle();
            r = int'($urandom % 100);
            if (r < 2) flush = 1;
            else if (r < 35) begin
                fill_en = 1; fill_large = ($urandom % 3) == 0;
                fill_vaddr = fill_large ? lg_va(int'($urandom % 3), int'($urandom % 8))
                                        : sm_va(int'($urandom % 8), int'($urandom % 16));
                fill_ppn = 28'($urandom); fill_writable = 1'($urandom); fill_user = 1'($urandom);
            end
            lk_valid = ($urandom % 8) != 0;
            lk_vaddr = (($urandom % 2) == 0) ? sm_va(int'($urandom % 8), int'($urandom % 16))
                                             : lg_va(int'($urandom % 3), int'($urandom % 8));
            lk_write = 1'($urandom); lk_user = 1'($urandom);
            #1;
            cyc(tag_for());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule